// File: doc/BRIEF.md
# Integer ALU for a 32-bit Load/Store Core

This block is the integer arithmetic and logic unit of a small 32-bit load/store processor. It is purely combinational. It takes two 32-bit operands, a 5-bit shift distance and a 4-bit operation code. It returns a 32-bit result and a flag that is high when that result is zero. The branch logic uses the flag: a subtract of two equal registers raises it.

Operand selection happens upstream of the block. That covers choosing a register or an immediate, and extending an immediate by sign or by zero. Operand B therefore already carries any immediate. The unit covers:

- addition and subtraction, both wrapping modulo 2^32;
- three bitwise operations: AND, OR and NOR (NOR against zero gives NOT);
- two logical shifts of operand B;
- signed and unsigned less-than compares, which return a 0/1 word;
- an upper-immediate load, which moves the low half of B into the high half.

Top module: `int_alu`

## Requirements
- R1: Code 0 returns a + b modulo 2^32; the carry out is dropped.
- R2: Code 1 returns a - b modulo 2^32.
- R3: Codes 2, 3 and 4 return bitwise AND, OR and NOR of a and b; NOR with b = 0 returns the inverse of a.
- R4: Code 5 returns b shifted left by shamt_i places with zeros entering at bit 0.
- R5: Code 6 returns b shifted right by shamt_i places with zeros entering at bit 31.
- R6: For codes 5 and 6, a shamt_i of 0 returns b unchanged; shamt_i has no effect on any other code.
- R7: Code 7 returns 1 when a is less than b as two's-complement numbers and 0 otherwise, correct even when a - b overflows.
- R8: Code 8 returns 1 when a is less than b as unsigned numbers and 0 otherwise.
- R9: Code 9 returns b[15:0] in bits 31:16 and zeros in bits 15:0; b[31:16] and a have no effect.
- R10: Code 9 on a 16-bit value H, then code 3 of that result with a zero-extended 16-bit value L, yields {H, L} (0xAAAA then 0x9999 gives 0xAAAA9999).
- R11: Codes 10 through 15 return 0.
- R12: zero_o is high exactly when result_o is 0; for code 1 it is high exactly when a equals b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; also the shifted value and the immediate source |
| shamt_i | input | 5 | Shift distance for codes 5 and 6 |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The bench targets pairs of operands whose signs differ and whose difference overflows. A compare that read only the sign of a - b would invert its answer for these pairs, for example when comparing 0x80000000 with 1. It drives the unsigned compare with operands whose top bits are set, where a signed compare returns the opposite answer.

Shifts run at distance 0, 1, 31 and random distances, so that a broken barrel stage, sign filling or a wrong stage order shows as wrong bits. The upper-immediate operation is given junk in b[31:16] to catch a block that does not mask the high half. It is then chained with OR to rebuild full constants.

Codes 10 to 15 are driven with nonzero operands, which exposes any decode that aliases an unused code to a real operation.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_LUI  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] add_o,
  output logic [W-1:0] sub_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W:0] diff_ext;
  logic       a_neg, b_neg;

  assign add_o    = a_i + b_i;
  assign diff_ext = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
  assign sub_o    = diff_ext[W-1:0];
  assign a_neg    = a_i[W-1];
  assign b_neg    = b_i[W-1];

  // borrow means a < b unsigned; on sign mismatch the operand signs decide
  assign lt_u_o = ~diff_ext[W];
  assign lt_s_o = (a_neg ^ b_neg) ? a_neg : diff_ext[W-1];

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_slt_signed_R7: assert (lt_s_o == ($signed(a_i) < $signed(b_i)))
        else $error("signed compare wrong");
      assert_slt_unsigned_R8: assert (lt_u_o == (a_i < b_i))
        else $error("unsigned compare wrong");
      assert_sub_equal_R12: assert ((a_i == b_i) == (sub_o == '0))
        else $error("difference zero mismatch");
      assert_add_sub_inverse_R2: assert (sub_o + b_i == a_i)
        else $error("difference not inverse of sum");
    end
  end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o,
  output logic [W-1:0] lui_o
);
  localparam int unsigned IMM_W = W / 2;

  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign nor_o = ~or_o;
  assign lui_o = {b_i[IMM_W-1:0], {(W-IMM_W){1'b0}}};

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_nor_not_R3: assert ((b_i != '0) || ((nor_o ^ a_i) == '1))
        else $error("nor with zero is not inverse");
      assert_lui_low_R9: assert (lui_o[W-IMM_W-1:0] == '0)
        else $error("upper immediate low half not clear");
      assert_lui_high_R9: assert ((lui_o >> (W-IMM_W)) == (b_i & ((W'(1) << IMM_W) - W'(1))))
        else $error("upper immediate high half wrong");
    end
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    b_i,
  input  logic [SH_W-1:0] shamt_i,
  output logic [W-1:0]    sll_o,
  output logic [W-1:0]    srl_o
);
  logic [W-1:0] l_stg [SH_W+1];
  logic [W-1:0] r_stg [SH_W+1];

  assign l_stg[0] = b_i;
  assign r_stg[0] = b_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign l_stg[k+1] = shamt_i[k] ? {l_stg[k][W-D-1:0], {D{1'b0}}} : l_stg[k];
    assign r_stg[k+1] = shamt_i[k] ? {{D{1'b0}}, r_stg[k][W-1:D]}   : r_stg[k];
  end

  assign sll_o = l_stg[SH_W];
  assign srl_o = r_stg[SH_W];

  always_comb begin
    if (!$isunknown({b_i, shamt_i})) begin
      assert_shift_zero_R6: assert ((shamt_i != '0) || (sll_o == b_i && srl_o == b_i))
        else $error("zero shift altered value");
      assert_sll_R4: assert (sll_o == (b_i << shamt_i))
        else $error("left shift wrong");
      assert_srl_R5: assert (srl_o == (b_i >> shamt_i))
        else $error("right shift wrong");
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [SH_W-1:0] shamt_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o
);
  logic [W-1:0] add_r, sub_r, and_r, or_r, nor_r, lui_r, sll_r, srl_r;
  logic         lt_s, lt_u;
  alu_op_e      op;

  assign op = alu_op_e'(op_i);

  int_alu_addsub #(.W(W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .add_o  (add_r),
    .sub_o  (sub_r),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  int_alu_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_r),
    .or_o  (or_r),
    .nor_o (nor_r),
    .lui_o (lui_r)
  );

  int_alu_shift #(.W(W), .SH_W(SH_W)) u_shift (
    .b_i     (b_i),
    .shamt_i (shamt_i),
    .sll_o   (sll_r),
    .srl_o   (srl_r)
  );

  always_comb begin
    case (op)
      OP_ADD:  result_o = add_r;
      OP_SUB:  result_o = sub_r;
      OP_AND:  result_o = and_r;
      OP_OR:   result_o = or_r;
      OP_NOR:  result_o = nor_r;
      OP_SLL:  result_o = sll_r;
      OP_SRL:  result_o = srl_r;
      OP_SLT:  result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(W-1){1'b0}}, lt_u};
      OP_LUI:  result_o = lui_r;
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    if (!$isunknown({a_i, b_i, shamt_i, op_i})) begin
      assert_unused_code_R11: assert ((op_i < 4'd10) || (result_o == '0 && zero_o))
        else $error("unused code gave nonzero result");
      assert_branch_equal_R12: assert ((op_i != 4'd1) || (zero_o == (a_i == b_i)))
        else $error("zero flag disagrees with equality");
      assert_compare_word_R7: assert ((op_i != 4'd7 && op_i != 4'd8) || (result_o[W-1:1] == '0))
        else $error("compare result not 0/1");
      assert_add_R1: assert ((op_i != 4'd0) || (result_o - b_i == a_i))
        else $error("sum wrong");
    end
  end
endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu u_int_alu (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op), .result_o(res), .zero_o(zf)
  );

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    case (o)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return ~(x | y);
      4'd5: return y << s;
      4'd6: return y >> s;
      4'd7: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd8: return (x < y) ? 32'd1 : 32'd0;
      4'd9: return {y[15:0], 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input string tag, input logic [3:0] o, input logic [31:0] x,
                     input logic [31:0] y, input logic [4:0] s);
    logic [31:0] exp;
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    #1;
    exp = model(o, x, y, s);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d got %h exp %h", tag, o, x, y, s, res, exp);
    end
    checks++;
    if (zf !== (exp == 32'd0)) begin
      errors++;
      $display("FAIL R12 op=%0d got zero=%b exp %b", o, zf, exp == 32'd0);
    end
  endtask

  initial begin
    logic [31:0] hi_word;
    void'($urandom(32'h5eed_1234));
    a = '0; b = '0; sh = '0; op = '0;
    #2;
    checks++;
    if (res !== 32'd0 || zf !== 1'b1) begin
      errors++;
      $display("FAIL R12 idle got %h/%b exp 0/1", res, zf);
    end

    run("R1", 4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);
    run("R1", 4'd0, 32'h7FFF_FFFF, 32'd1, 5'd3);
    run("R2", 4'd1, 32'd0, 32'd1, 5'd0);
    run("R12", 4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0);
    run("R3", 4'd4, 32'hA5A5_0F0F, 32'd0, 5'd0);
    run("R3", 4'd2, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 5'd9);
    run("R4", 4'd5, 32'h0, 32'h8000_0001, 5'd1);
    run("R4", 4'd5, 32'h0, 32'hFFFF_FFFF, 5'd31);
    run("R5", 4'd6, 32'h0, 32'h8000_0000, 5'd31);
    run("R5", 4'd6, 32'h0, 32'hFFFF_FFFF, 5'd1);
    run("R6", 4'd5, 32'h0, 32'hDEAD_BEEF, 5'd0);
    run("R6", 4'd6, 32'h0, 32'hDEAD_BEEF, 5'd0);
    run("R6", 4'd0, 32'd3, 32'd4, 5'd17);
    run("R7", 4'd7, 32'h8000_0000, 32'd1, 5'd0);
    run("R7", 4'd7, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    run("R7", 4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    run("R8", 4'd8, 32'd1, 32'h8000_0000, 5'd0);
    run("R8", 4'd8, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 5'd0);
    run("R9", 4'd9, 32'hFFFF_FFFF, 32'h1234_AAAA, 5'd4);
    for (int c = 10; c < 16; c++) run("R11", 4'(c), 32'hFFFF_FFFF, 32'h1357_9BDF, 5'd7);

    // R10: upper immediate then OR rebuilds constant
    @(negedge clk);
    op = 4'd9; a = 32'h0; b = 32'h0000_AAAA; sh = 5'd0;
    #1;
    hi_word = res;
    run("R10", 4'd3, hi_word, 32'h0000_9999, 5'd0);
    checks++;
    if (res !== 32'hAAAA_9999) begin
      errors++;
      $display("FAIL R10 got %h exp %h", res, 32'hAAAA_9999);
    end

    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  o;
      logic [31:0] x, y;
      o = 4'($urandom_range(0, 15));
      x = $urandom();
      y = $urandom();
      if (($urandom() & 3) == 0) y = x;
      if (($urandom() & 3) == 0) x = {~y[31], x[30:0]};
      run(tag_of(o), o, x, y, 5'($urandom()));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule